// File: doc/BRIEF.md
# Command Queue Consumer

This block drains a circular queue of 64-bit commands that software places in memory. Software programs a base register, which gives both the queue address and its size as a power of two, and then moves a producer index. The consumer reads each pending entry through a simple memory read port and decodes its opcode. Each command becomes one of three things: a one-cycle invalidate request to the caches downstream, a sync interrupt pulse, or nothing at all. The consumer index moves past a command only after that command has been handled.

A command that cannot be fetched, or that is not legal, stops the queue. The block then records an error code and toggles a global error flag. Nothing more is consumed until software makes its acknowledge bit equal to the flag again. That acknowledge write also restarts consumption, beginning at the command that failed. The block does not carry out the invalidations and does not walk any tables.

Top module: `cmdq_consumer`

## Requirements
- R1: A base write (select 1) takes the queue log2 size from data bits [4:0] and clamps it to MAX_LG2 when larger; bits [31:5] form the 32-byte aligned queue address.
- R2: Consumption is started only by a write to control (select 0), producer (select 2) or acknowledge (select 4), and only while control bit 0 (enable) is set; with enable clear no command is consumed.
- R3: Indices carry a wrap bit at position log2 size; the queue is empty when index and wrap both match, a full queue (wrap differs) is drained completely, and entry i is read at queue address + 8*i.
- R4: Command fields: opcode [7:0], secure flag [8], sync mode [10:9], range [15:11], ID [31:16], address [63:32]. Opcodes 0x03/0x05/0x06 give kind 1 (stream), 0x04 kind 2 (range), 0x11 kind 3 (ASID), 0x15 kind 4 (address with ASID), 0x14 kind 5 (address, any ASID), 0x12/0x13 kind 6 (all). Each gives one inv_valid pulse in queue order, with inv_lo = ID, inv_hi = ID and inv_addr = address.
- R5: A range command reports inv_hi = ID + 2^(range+1) - 1, saturated at the largest stream ID.
- R6: A config invalidation (0x03, 0x04, 0x05, 0x06) with the secure flag set is illegal.
- R7: A sync command (0x46) with sync mode 01 gives a one-cycle sync_irq pulse; any other mode completes silently.
- R8: Prefetch opcodes 0x01 and 0x02, and opcodes 0x20 through 0x2B, are consumed with no output.
- R9: An unknown opcode sets err_code to 1 and a failed read sets it to 2; in both cases err_flag toggles and the consumer index stays on the failing command.
- R10: While err_flag differs from err_ack, no command is consumed, even after a kick; writing an acknowledge (select 4, bit 0) equal to err_flag resumes from the failing command.
- R11: The consumer index changes only by software write or by one step per completed command.
- R12: After reset the indices, log2 size, error state and all pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 base, 2 producer, 3 consumer, 4 acknowledge |
| reg_wdata | input | 32 | Register write data |
| mem_rd_req | output | 1 | Read request, held until answered |
| mem_rd_addr | output | ADDR_W | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read response valid |
| mem_rd_err | input | 1 | Read response failed |
| mem_rd_data | input | 64 | Command word |
| inv_valid | output | 1 | Invalidate request pulse |
| inv_kind | output | 3 | Invalidate kind (R4 coding) |
| inv_lo | output | SID_W | Stream ID start or ASID |
| inv_hi | output | SID_W | Stream ID end |
| inv_addr | output | 32 | Address operand |
| sync_irq | output | 1 | Sync interrupt pulse |
| cq_lg2 | output | 5 | Effective queue log2 size |
| cq_prod | output | MAX_LG2+1 | Producer index with wrap |
| cq_cons | output | MAX_LG2+1 | Consumer index with wrap |
| err_flag | output | 1 | Global command-queue error flag |
| err_ack | output | 1 | Software acknowledge bit |
| err_code | output | 2 | Last error code |

## Verification
A wrong consumer index shows up in two ways. Commands are skipped or repeated in the invalidate stream, and the final index read at the ports differs from the model's. The first misplaced pulse appears within a few cycles of the fetch. A decode fault produces the wrong kind or operands on the first affected command. A broken freeze shows as invalidate pulses appearing while the error flag and the acknowledge bit differ, and a broken range shows as a wrong or inverted upper stream ID.

// File: rtl/cmdq_pkg.sv
// Shared types, opcode values and command field positions for the command
// queue consumer. Assumes 64-bit commands stored 8 bytes apart in memory.
package cmdq_pkg;
    localparam int CMD_W       = 64;
    localparam int ENTRY_SHIFT = 3;
    localparam int LG_W        = 5;

    // command field positions
    localparam int F_SEC     = 8;
    localparam int F_CS_LSB  = 9;
    localparam int F_RNG_LSB = 11;
    localparam int F_ID_LSB  = 16;
    localparam int F_AD_LSB  = 32;
    localparam logic [1:0] CS_IRQ = 2'b01;

    // opcodes
    localparam logic [7:0] OP_PF_CFG       = 8'h01;
    localparam logic [7:0] OP_PF_ADDR      = 8'h02;
    localparam logic [7:0] OP_CFG_STREAM   = 8'h03;
    localparam logic [7:0] OP_CFG_RANGE    = 8'h04;
    localparam logic [7:0] OP_CFG_CTX      = 8'h05;
    localparam logic [7:0] OP_CFG_CTX_ALL  = 8'h06;
    localparam logic [7:0] OP_TLB_ASID     = 8'h11;
    localparam logic [7:0] OP_TLB_ALL      = 8'h12;
    localparam logic [7:0] OP_TLB_ALL_NS   = 8'h13;
    localparam logic [7:0] OP_TLB_ADDR_ANY = 8'h14;
    localparam logic [7:0] OP_TLB_ADDR     = 8'h15;
    localparam logic [7:0] OP_NOOP_LO      = 8'h20;
    localparam logic [7:0] OP_NOOP_HI      = 8'h2B;
    localparam logic [7:0] OP_SYNC         = 8'h46;

    typedef enum logic [2:0] {
        INV_NONE     = 3'd0,
        INV_STREAM   = 3'd1,
        INV_RANGE    = 3'd2,
        INV_ASID     = 3'd3,
        INV_ADDR     = 3'd4,
        INV_ADDR_ANY = 3'd5,
        INV_ALL      = 3'd6
    } inv_kind_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_ILLEGAL = 2'd1,
        ERR_ABORT   = 2'd2
    } err_code_e;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_BASE = 3'd1,
        SEL_PROD = 3'd2,
        SEL_CONS = 3'd3,
        SEL_ACK  = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_EXEC
    } cq_state_e;
endpackage

// File: rtl/cmdq_regs.sv
// Queue registers: enable, base/size, producer and consumer indices.
// Derives the empty condition and the read address of the current entry.
// Assumes MAX_LG2 < 31; indices keep a wrap bit at position lg2.
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int MAX_LG2 = 4,
    parameter int ADDR_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_sel,
    input  logic [31:0]          reg_wdata,
    input  logic                 advance,
    output logic                 en,
    output logic [LG_W-1:0]      lg2,
    output logic [MAX_LG2:0]     prod,
    output logic [MAX_LG2:0]     cons,
    output logic                 empty,
    output logic [ADDR_W-1:0]    rd_addr
);
    localparam int PW = MAX_LG2 + 1;
    localparam logic [LG_W-1:0] LG_MAX = LG_W'(MAX_LG2);

    logic              en_q;
    logic [LG_W-1:0]   lg_q;
    logic [ADDR_W-1:0] base_q;
    logic [PW-1:0]     prod_q, cons_q;
    logic [PW-1:0]     wrap_mask, idx_mask, slot;

    // masks covering index plus wrap, and index alone
    always_comb begin
        wrap_mask = {PW{1'b1}} >> (LG_MAX - lg_q);
        idx_mask  = {PW{1'b1}} >> (LG_W'(PW) - lg_q);
        slot      = cons_q & idx_mask;
        empty     = ((prod_q ^ cons_q) & wrap_mask) == '0;
        rd_addr   = base_q + (ADDR_W'(slot) << ENTRY_SHIFT);
    end

    // register updates from software writes and consumer advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lg_q   <= '0;
            base_q <= '0;
            prod_q <= '0;
            cons_q <= '0;
        end else begin
            if (reg_we && reg_sel == SEL_CTRL)
                en_q <= reg_wdata[0];
            if (reg_we && reg_sel == SEL_BASE) begin
                base_q <= ADDR_W'({reg_wdata[31:5], 5'b0});
                lg_q   <= (reg_wdata[4:0] > LG_MAX) ? LG_MAX : reg_wdata[4:0];
            end
            if (reg_we && reg_sel == SEL_PROD)
                prod_q <= reg_wdata[PW-1:0];
            if (reg_we && reg_sel == SEL_CONS)
                cons_q <= reg_wdata[PW-1:0];
            else if (advance)
                cons_q <= (cons_q + 1'b1) & wrap_mask;
        end
    end

    assign en   = en_q;
    assign lg2  = lg_q;
    assign prod = prod_q;
    assign cons = cons_q;
endmodule

// File: rtl/cmdq_decode.sv
// Combinational decode of the low word of a command into an action:
// invalidate kind with stream/ASID bounds, sync interrupt, or illegal.
// Assumes SID_W <= 16 (the ID field is 16 bits wide).
module cmdq_decode
    import cmdq_pkg::*;
#(
    parameter int SID_W = 16
) (
    input  logic [31:0]      cmd_lo,
    output logic             illegal,
    output logic             sync_req,
    output inv_kind_e        kind,
    output logic [SID_W-1:0] lo,
    output logic [SID_W-1:0] hi
);
    localparam logic [63:0] SID_MAX = 64'({SID_W{1'b1}});

    logic [7:0]       op;
    logic             sec;
    logic [1:0]       cs;
    logic [4:0]       rng;
    logic [SID_W-1:0] id;
    logic [63:0]      range_sum;
    logic [SID_W-1:0] range_end;

    // field extraction and saturating range end
    always_comb begin
        op        = cmd_lo[7:0];
        sec       = cmd_lo[F_SEC];
        cs        = cmd_lo[F_CS_LSB +: 2];
        rng       = cmd_lo[F_RNG_LSB +: 5];
        id        = cmd_lo[F_ID_LSB +: SID_W];
        range_sum = 64'(id) + ((64'd1 << ({1'b0, rng} + 6'd1)) - 64'd1);
        range_end = (range_sum > SID_MAX) ? {SID_W{1'b1}} : range_sum[SID_W-1:0];
    end

    // opcode to action mapping
    always_comb begin
        illegal  = 1'b0;
        sync_req = 1'b0;
        kind     = INV_NONE;
        lo       = id;
        hi       = id;
        case (op) inside
            OP_CFG_STREAM, OP_CFG_CTX, OP_CFG_CTX_ALL: begin
                if (sec) illegal = 1'b1;
                else     kind    = INV_STREAM;
            end
            OP_CFG_RANGE: begin
                if (sec) illegal = 1'b1;
                else begin
                    kind = INV_RANGE;
                    hi   = range_end;
                end
            end
            OP_TLB_ASID:               kind = INV_ASID;
            OP_TLB_ALL, OP_TLB_ALL_NS: kind = INV_ALL;
            OP_TLB_ADDR_ANY:           kind = INV_ADDR_ANY;
            OP_TLB_ADDR:               kind = INV_ADDR;
            OP_SYNC:                   sync_req = (cs == CS_IRQ);
            OP_PF_CFG, OP_PF_ADDR, [OP_NOOP_LO:OP_NOOP_HI]: begin
            end
            default:                   illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/cmdq_errctl.sv
// Global error handshake: a flag toggled by the consumer and an acknowledge
// bit written by software; a difference between them means pending.
// Assumes the consumer raises only while nothing is pending.
module cmdq_errctl
    import cmdq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      raise,
    input  err_code_e raise_code,
    input  logic      ack_we,
    input  logic      ack_bit,
    output logic      flag,
    output logic      ack,
    output err_code_e code,
    output logic      pending
);
    logic      flag_q, ack_q;
    err_code_e code_q;

    assign pending = flag_q ^ ack_q;

    // flag toggle on a new error, code capture, acknowledge store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ack_q  <= 1'b0;
            code_q <= ERR_NONE;
        end else begin
            if (raise && !pending) begin
                flag_q <= ~flag_q;
                code_q <= raise_code;
            end
            if (ack_we)
                ack_q <= ack_bit;
        end
    end

    assign flag = flag_q;
    assign ack  = ack_q;
    assign code = code_q;
endmodule

// File: rtl/cmdq_consumer.sv
// Top of the command queue consumer. A kick (write to control, producer or
// acknowledge) starts a loop: check empty/pending, fetch one entry, execute
// it, advance the consumer index, repeat. Errors stop the loop without
// advancing. Assumes the memory port answers every request eventually.
module cmdq_consumer
    import cmdq_pkg::*;
#(
    parameter int MAX_LG2 = 4,
    parameter int SID_W   = 16,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_sel,
    input  logic [31:0]        reg_wdata,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic               mem_rd_err,
    input  logic [63:0]        mem_rd_data,
    output logic               inv_valid,
    output logic [2:0]         inv_kind,
    output logic [SID_W-1:0]   inv_lo,
    output logic [SID_W-1:0]   inv_hi,
    output logic [31:0]        inv_addr,
    output logic               sync_irq,
    output logic [4:0]         cq_lg2,
    output logic [MAX_LG2:0]   cq_prod,
    output logic [MAX_LG2:0]   cq_cons,
    output logic               err_flag,
    output logic               err_ack,
    output logic [1:0]         err_code
);
    cq_state_e        state_q, state_d;
    logic             kick, kick_q;
    logic [63:0]      cmd_q;
    logic             rerr_q;
    logic             en, empty, pending;
    logic             dec_illegal, dec_sync;
    inv_kind_e        dec_kind;
    logic [SID_W-1:0] dec_lo, dec_hi;
    logic             in_exec, fail, advance, raise;
    err_code_e        raise_code, code;

    assign kick = reg_we && (reg_sel == SEL_PROD || reg_sel == SEL_CTRL ||
                             reg_sel == SEL_ACK);

    cmdq_regs #(.MAX_LG2(MAX_LG2), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .advance(advance),
        .en(en), .lg2(cq_lg2), .prod(cq_prod), .cons(cq_cons),
        .empty(empty), .rd_addr(mem_rd_addr)
    );

    cmdq_decode #(.SID_W(SID_W)) u_dec (
        .cmd_lo(cmd_q[31:0]),
        .illegal(dec_illegal), .sync_req(dec_sync), .kind(dec_kind),
        .lo(dec_lo), .hi(dec_hi)
    );

    cmdq_errctl u_err (
        .clk(clk), .rst_n(rst_n),
        .raise(raise), .raise_code(raise_code),
        .ack_we(reg_we && reg_sel == SEL_ACK), .ack_bit(reg_wdata[0]),
        .flag(err_flag), .ack(err_ack), .code(code), .pending(pending)
    );

    // outcome of the command held in the execute stage
    always_comb begin
        in_exec    = (state_q == ST_EXEC);
        fail       = rerr_q || dec_illegal;
        advance    = in_exec && !fail;
        raise      = in_exec && fail;
        raise_code = rerr_q ? ERR_ABORT : ERR_ILLEGAL;
    end

    // next-state selection for the consume loop
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (kick_q && en) state_d = ST_CHECK;
            ST_CHECK: state_d = (!en || empty || pending) ? ST_IDLE : ST_FETCH;
            ST_FETCH: if (mem_rd_valid) state_d = ST_EXEC;
            ST_EXEC:  state_d = fail ? ST_IDLE : ST_CHECK;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state, kick latch and fetched command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kick_q  <= 1'b0;
            cmd_q   <= '0;
            rerr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (kick)
                kick_q <= 1'b1;
            else if (state_q == ST_IDLE && en)
                kick_q <= 1'b0;
            if (state_q == ST_FETCH && mem_rd_valid) begin
                cmd_q  <= mem_rd_data;
                rerr_q <= mem_rd_err;
            end
        end
    end

    assign mem_rd_req = (state_q == ST_FETCH);
    assign inv_valid  = advance && (dec_kind != INV_NONE);
    assign inv_kind   = dec_kind;
    assign inv_lo     = dec_lo;
    assign inv_hi     = dec_hi;
    assign inv_addr   = cmd_q[F_AD_LSB +: 32];
    assign sync_irq   = advance && dec_sync;
    assign err_code   = code;
endmodule

// File: rtl/cmdq_consumer_chk.sv
// Property checker for the command queue consumer, bound to every instance.
module cmdq_consumer_chk
    import cmdq_pkg::*;
#(
    parameter int MAX_LG2 = 4,
    parameter int SID_W   = 16,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [2:0]         reg_sel,
    input logic               mem_rd_req,
    input logic [ADDR_W-1:0]  mem_rd_addr,
    input logic               mem_rd_valid,
    input logic               inv_valid,
    input logic [2:0]         inv_kind,
    input logic [SID_W-1:0]   inv_lo,
    input logic [SID_W-1:0]   inv_hi,
    input logic               sync_irq,
    input logic [4:0]         cq_lg2,
    input logic [MAX_LG2:0]   cq_cons,
    input logic               err_flag,
    input logic               err_ack
);
    localparam int PW = MAX_LG2 + 1;

    logic          we_cons;
    logic [PW-1:0] step_next;

    always_comb begin
        we_cons   = reg_we && reg_sel == SEL_CONS;
        step_next = (cq_cons + 1'b1) & ({PW{1'b1}} >> (5'(MAX_LG2) - cq_lg2));
    end

    assert_lg2_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cq_lg2 <= 5'(MAX_LG2));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_range_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_kind == INV_RANGE) |-> (inv_hi >= inv_lo));

    assert_sync_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq |=> !sync_irq);

    assert_err_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flag != $past(err_flag)) && !$past(we_cons)) |-> (cq_cons == $past(cq_cons)));

    assert_fetch_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_req) |-> ($past(err_flag) == $past(err_ack)));

    assert_cons_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cq_cons != $past(cq_cons)) && !$past(we_cons)) |-> (cq_cons == $past(step_next)));
endmodule

bind cmdq_consumer cmdq_consumer_chk #(
    .MAX_LG2(MAX_LG2), .SID_W(SID_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sim_cmdq_consumer.sv
// Bench: behavioural queue model predicts every output pulse; monitor
// compares them at each falling edge, phases check registers at the ports.
module sim_cmdq_consumer;
    import cmdq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic        mem_rd_err;
    logic [63:0] mem_rd_data;
    logic        inv_valid, sync_irq;
    logic [2:0]  inv_kind;
    logic [15:0] inv_lo, inv_hi;
    logic [31:0] inv_addr;
    logic [4:0]  cq_lg2;
    logic [4:0]  cq_prod, cq_cons;
    logic        err_flag, err_ack;
    logic [1:0]  err_code;

    always #4 clk = ~clk;

    cmdq_consumer u0 (.*);

    logic [63:0] mem [0:63];
    int          bad_w = -1;
    int          nchk = 0, nfail = 0, cyc = 0;
    bit          done = 0;
    logic [66:0] exp_q[$];

    // model state
    int m_en = 0, m_lg = 0, m_base = 0, m_prod = 0, m_cons = 0;
    int m_flag = 0, m_ack = 0, m_code = 0;

    // memory responder, one cycle latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_valid <= 1'b0;
            mem_rd_err   <= 1'b0;
            mem_rd_data  <= '0;
        end else begin
            mem_rd_valid <= mem_rd_req && !mem_rd_valid;
            mem_rd_data  <= mem[(mem_rd_addr >> 3) & 63];
            mem_rd_err   <= (int'((mem_rd_addr >> 3) & 63) == bad_w);
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare every output pulse against the model's prediction
    always @(negedge clk) begin
        if (rst_n && (inv_valid || sync_irq)) begin
            logic [66:0] act;
            string req;
            act = sync_irq ? {3'd7, 64'd0} : {inv_kind, inv_lo, inv_hi, inv_addr};
            req = sync_irq ? "R7" : (inv_kind == 3'd2 ? "R5" : "R4");
            if (exp_q.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL %s unexpected pulse actual=%0h expected=none", req, act);
            end else begin
                logic [66:0] e;
                e = exp_q.pop_front();
                chk(req, "pulse", longint'(act[63:0]) ^ (longint'(act[66:64]) << 61),
                    longint'(e[63:0]) ^ (longint'(e[66:64]) << 61));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    function automatic logic [63:0] mk(input int op, input int sec, input int cs,
                                       input int rng, input int id, input int ad);
        return {32'(ad), 16'(id), 5'(rng), 2'(cs), 1'(sec), 8'(op)};
    endfunction

    task automatic model_run();
        bit go = 1;
        while (go) begin
            int wm, slot, w;
            wm = (1 << (m_lg + 1)) - 1;
            if (m_en == 0 || ((m_prod ^ m_cons) & wm) == 0 || m_flag != m_ack) go = 0;
            else begin
                slot = m_cons & ((1 << m_lg) - 1);
                w = ((m_base + slot * 8) >> 3) & 63;
                if (w == bad_w) begin
                    m_flag ^= 1; m_code = 2; go = 0;
                end else begin
                    logic [63:0] c;
                    int op, k, hi;
                    bit bad;
                    longint e;
                    c = mem[w]; op = c[7:0]; k = 0; bad = 0; hi = c[31:16];
                    case (op)
                        3, 5, 6: if (c[8]) bad = 1; else k = 1;
                        4: begin
                            if (c[8]) bad = 1;
                            else begin
                                k = 2;
                                e = longint'(c[31:16]) + (longint'(1) << (c[15:11] + 1)) - 1;
                                hi = (e > 65535) ? 65535 : int'(e);
                            end
                        end
                        'h11: k = 3;
                        'h15: k = 4;
                        'h14: k = 5;
                        'h12, 'h13: k = 6;
                        'h46: if (c[10:9] == 2'b01) exp_q.push_back({3'd7, 64'd0});
                        1, 2: ;
                        default: if (op < 'h20 || op > 'h2B) bad = 1;
                    endcase
                    if (bad) begin
                        m_flag ^= 1; m_code = 1; go = 0;
                    end else begin
                        if (k != 0) exp_q.push_back({3'(k), c[31:16], 16'(hi), c[63:32]});
                        m_cons = (m_cons + 1) & wm;
                    end
                end
            end
        end
    endtask

    task automatic wr(input reg_sel_e sel, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = 32'(d);
        @(negedge clk);
        reg_we = 1'b0;
        case (sel)
            SEL_CTRL: m_en = d & 1;
            SEL_BASE: begin m_lg = ((d & 31) > 4) ? 4 : (d & 31); m_base = d & ~31; end
            SEL_PROD: m_prod = d & 31;
            SEL_CONS: m_cons = d & 31;
            SEL_ACK:  m_ack = d & 1;
            default: ;
        endcase
        if (sel != SEL_BASE && sel != SEL_CONS) model_run();
    endtask

    task automatic put(input int slot, input logic [63:0] c);
        mem[8 + slot] = c;
    endtask

    task automatic settle();
        repeat (120) @(negedge clk);
        chk("R4", "pending pulses", exp_q.size(), 0);
    endtask

    task automatic regs_match(input string req);
        chk(req, "cons", cq_cons, m_cons);
        chk(req, "err_flag", err_flag, m_flag);
        chk(req, "err_code", err_code, m_code);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "cons", cq_cons, 0);
        chk("R12", "lg2", cq_lg2, 0);
        chk("R12", "err_flag", err_flag, 0);
        chk("R12", "err_code", err_code, 0);
        chk("R12", "pulses", {inv_valid, sync_irq, mem_rd_req}, 0);

        // R1 size clamp
        wr(SEL_BASE, 'h40 | 9);
        chk("R1", "lg2 clamp", cq_lg2, 4);
        wr(SEL_BASE, 'h40 | 3);
        chk("R1", "lg2", cq_lg2, 3);
        wr(SEL_BASE, 'h40 | 4);
        chk("R1", "lg2", cq_lg2, 4);

        // R2 disabled queue is not consumed
        put(0, mk('h03, 0, 0, 0, 5, 'h1000));
        put(1, mk('h11, 0, 0, 0, 7, 'h2000));
        wr(SEL_PROD, 2);
        settle();
        chk("R2", "cons while disabled", cq_cons, 0);
        wr(SEL_CTRL, 1);
        settle();
        chk("R2", "cons after enable", cq_cons, 2);

        // R4 R5 R7 R8 mixed commands
        put(2, mk('h04, 0, 0, 2, 8, 0));
        put(3, mk('h15, 0, 0, 0, 3, 'hdead1000));
        put(4, mk('h14, 0, 0, 0, 0, 'hbeef2000));
        put(5, mk('h12, 0, 0, 0, 0, 0));
        put(6, mk('h13, 0, 0, 0, 0, 0));
        put(7, mk('h05, 0, 0, 0, 9, 0));
        put(8, mk('h01, 0, 0, 0, 1, 0));
        put(9, mk('h25, 0, 0, 0, 1, 0));
        put(10, mk('h46, 0, 1, 0, 0, 0));
        put(11, mk('h46, 0, 0, 0, 0, 0));
        put(12, mk('h06, 0, 0, 0, 12, 'h40));
        wr(SEL_PROD, 13);
        settle();
        regs_match("R8");

        // R3 wrap with a full queue of four
        wr(SEL_CONS, 0);
        wr(SEL_PROD, 0);
        wr(SEL_BASE, 'h40 | 2);
        for (int i = 0; i < 4; i++) put(i, mk('h11, 0, 0, 0, 100 + i, i));
        wr(SEL_PROD, 4);
        settle();
        chk("R3", "cons after full drain", cq_cons, 4);
        put(0, mk('h11, 0, 0, 0, 110, 0));
        put(1, mk('h11, 0, 0, 0, 111, 0));
        wr(SEL_PROD, 6);
        settle();
        chk("R3", "cons after wrap", cq_cons, 6);

        // R9 illegal opcode
        wr(SEL_CONS, 0);
        wr(SEL_PROD, 0);
        wr(SEL_BASE, 'h40 | 4);
        put(0, mk('h11, 0, 0, 0, 20, 0));
        put(1, mk('hFF, 0, 0, 0, 21, 0));
        put(2, mk('h11, 0, 0, 0, 22, 0));
        wr(SEL_PROD, 3);
        settle();
        regs_match("R9");
        chk("R9", "code illegal", err_code, 1);

        // R10 frozen until acknowledged
        put(1, mk('h11, 0, 0, 0, 21, 0));
        wr(SEL_PROD, 3);
        settle();
        chk("R10", "cons frozen", cq_cons, 1);
        wr(SEL_ACK, 1);
        settle();
        regs_match("R10");
        chk("R10", "cons resumed", cq_cons, 3);

        // R6 secure config invalidation
        put(3, mk('h03, 1, 0, 0, 30, 0));
        wr(SEL_PROD, 4);
        settle();
        regs_match("R6");
        chk("R6", "cons", cq_cons, 3);
        // R5 saturating range after fixing the entry
        put(3, mk('h04, 0, 0, 7, 'hFFF0, 0));
        wr(SEL_ACK, 0);
        settle();
        regs_match("R5");

        // R9 read abort
        bad_w = 8 + 4;
        put(4, mk('h11, 0, 0, 0, 40, 0));
        wr(SEL_PROD, 5);
        settle();
        regs_match("R9");
        chk("R9", "code abort", err_code, 2);
        bad_w = -1;
        wr(SEL_ACK, 1);
        settle();
        regs_match("R11");
        chk("R11", "cons final", cq_cons, 5);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule